// File: doc/BRIEF.md
# Octave-adaptive PWM tone generator

This block turns a requested note into a single-bit pulse-width-modulated audio stream. The note is given as an octave number and a fine divisor. A single mapping stage derives both the PWM word width and the prescaler period from that request. Up to octave 3 the PWM runs with the full 8-bit resolution, and the prescaler period doubles for each octave below 3. Above octave 3 the prescaler runs at the fine divisor alone, and one resolution bit is dropped per octave. As a result, every octave step halves the PWM frame length. High notes therefore carry no PWM detail that a fixed reconstruction filter would only discard, and the master clock can stay modest.

A waveform source supplies the duty value. The block asks for the next value with a one-cycle strobe each time it captures one. Low-order sample bits that the current resolution cannot express are dropped.

A second mode keeps the PWM at full resolution and a constant frame rate. Only the number of frames per sample changes, as a power of two chosen by octave. A new note request never cuts a frame short: the new setting is adopted when the running frame ends.

Top module: `tone_pwm_gen`

## Requirements
- R1: While reset is asserted, `pwm_out` and `sample_req` are low. Within 6 clocks of reset release, the first frame starts and `sample_req` pulses.
- R2: In adaptive mode (`tone_mode`=0), the PWM resolution is 8 bits for octaves 0 to 3. Above octave 3 it is 8-(octave-3) bits, so octave 9 gives 2 bits and octave 10 gives 1 bit.
- R3: In adaptive mode, one counter step lasts (fine_div+1)<<(3-octave) clocks for octaves 0 to 3, and (fine_div+1) clocks above octave 3. A frame lasts one step multiplied by 2^resolution.
- R4: The threshold is sample>>(8-resolution). Each frame begins with `pwm_out` high while the step counter is below the threshold. Over a frame, the output is high for threshold×step clocks.
- R5: Sample bits below the current resolution have no effect: at 1-bit resolution, sample 0x7F gives a frame with no high cycles.
- R6: Octave values above 10 act as octave 10. In adaptive mode this means 1-bit resolution; in fixed-rate mode it means one frame per sample.
- R7: `sample_req` is high for exactly one clock, in the clock after the edge that captures `sample_in`. In adaptive mode this happens once per frame.
- R8: Changes of `oct_sel`, `fine_div` or `tone_mode` take effect only at the end of the frame in progress. The frame in progress keeps its length and duty.
- R9: In fixed-rate mode (`tone_mode`=1), the resolution is 8 bits and a step lasts fine_div+1 clocks. A sample is captured, and `sample_req` pulses, once every 2^(10-octave) frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_mode | input | 1 | 0 = octave-adaptive resolution, 1 = fixed-rate full resolution |
| oct_sel | input | 4 | Requested octave, 0 to 10 (larger values clamp) |
| fine_div | input | 8 | Fine divisor; a step lasts fine_div+1 base clocks |
| sample_in | input | 8 | Duty value from the waveform source |
| pwm_out | output | 1 | PWM bitstream |
| sample_req | output | 1 | One-cycle request for the next sample |

## Verification
The assertions take for granted that the note request and sample only move between clock edges. They also assume that `sample_in` is meaningful whenever the block captures it, since the block samples it without a handshake. The bench changes every input at the falling clock edge and holds each setting for several whole frames before it measures anything. This keeps each captured value and each loaded configuration unambiguous. A single deliberate mid-frame change checks that the frame in progress is left intact.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
  typedef enum logic {
    MODE_ADAPTIVE = 1'b0,
    MODE_LOCKED   = 1'b1
  } tone_mode_e;
endpackage

// File: rtl/tone_oct_map.sv
`timescale 1ns/1ps
// Maps a note request onto PWM resolution, step period and sample group size.
module tone_oct_map
  import tone_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int OCT_W    = 4,
  parameter int DIV_W    = 8,
  parameter int FULL_OCT = 4,
  parameter int TOP_OCT  = 10,
  localparam int RES_W   = $clog2(SAMPLE_W + 1),
  localparam int PER_W   = DIV_W + FULL_OCT,
  localparam int GEXP_W  = $clog2(TOP_OCT + 1)
) (
  input  logic              mode_i,
  input  logic [OCT_W-1:0]  oct_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [RES_W-1:0]  res_o,
  output logic [PER_W-1:0]  per_o,
  output logic [GEXP_W-1:0] gexp_o
);
  localparam logic [OCT_W-1:0] OCT_TOP  = OCT_W'(TOP_OCT);
  localparam logic [OCT_W-1:0] OCT_KNEE = OCT_W'(FULL_OCT - 1);

  logic [OCT_W-1:0] oct_c;
  logic [OCT_W-1:0] drop;
  logic [PER_W-1:0] base;

  always_comb begin
    oct_c  = (oct_i > OCT_TOP) ? OCT_TOP : oct_i;
    base   = PER_W'(div_i) + PER_W'(1);
    drop   = '0;
    res_o  = RES_W'(SAMPLE_W);
    per_o  = base;
    gexp_o = '0;
    if (tone_mode_e'(mode_i) == MODE_LOCKED) begin
      gexp_o = GEXP_W'(TOP_OCT) - GEXP_W'(oct_c);
    end else if (oct_c < OCT_W'(FULL_OCT)) begin
      per_o = base << (OCT_KNEE - oct_c);
    end else begin
      drop = oct_c - OCT_KNEE;
      if (drop >= OCT_W'(SAMPLE_W)) begin
        res_o = RES_W'(1);
      end else begin
        res_o = RES_W'(SAMPLE_W) - RES_W'(drop);
      end
    end
  end
endmodule

// File: rtl/tone_prescaler.sv
`timescale 1ns/1ps
// Step-rate clock enable: one tick every per_i clocks while running.
module tone_prescaler #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PER_W-1:0] per_i,
  output logic             tick_o
);
  logic [PER_W-1:0] pre_q, pre_d;

  always_comb begin
    tick_o = run_i && (pre_q == per_i - PER_W'(1));
    if (!run_i || tick_o) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/tone_frame_core.sv
`timescale 1ns/1ps
// Frame counter, configuration holding registers, sample capture and PWM compare.
module tone_frame_core #(
  parameter int SAMPLE_W = 8,
  parameter int RES_W    = 4,
  parameter int PER_W    = 12,
  parameter int GEXP_W   = 4,
  parameter int GRP_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [RES_W-1:0]    res_n_i,
  input  logic [PER_W-1:0]    per_n_i,
  input  logic [GEXP_W-1:0]   gexp_n_i,
  output logic                run_o,
  output logic                boundary_o,
  output logic [PER_W-1:0]    per_o,
  output logic [RES_W-1:0]    res_o,
  output logic [SAMPLE_W-1:0] thr_o,
  output logic [SAMPLE_W-1:0] cnt_o,
  output logic                pwm_o,
  output logic                req_o
);
  localparam logic [RES_W-1:0]    FULL_RES = RES_W'(SAMPLE_W);
  localparam logic [SAMPLE_W-1:0] ONES     = {SAMPLE_W{1'b1}};
  localparam logic [GRP_W-1:0]    GONES    = {GRP_W{1'b1}};

  logic                run_q;
  logic [SAMPLE_W-1:0] cnt_q, cnt_d, cnt_top;
  logic [RES_W-1:0]    res_q;
  logic [PER_W-1:0]    per_q;
  logic [GEXP_W-1:0]   gexp_q;
  logic [GRP_W-1:0]    grp_q, grp_d, grp_top;
  logic [SAMPLE_W-1:0] thr_q, thr_d;
  logic                pwm_q, pwm_d;
  logic                req_q;
  logic                frame_end, boundary, take;
  logic                cfg_en, cnt_en, thr_en, grp_en;

  // next-state logic
  always_comb begin
    cnt_top   = ONES >> (FULL_RES - res_q);
    grp_top   = GONES >> (GEXP_W'(GRP_W) - gexp_q);
    frame_end = tick_i && (cnt_q == cnt_top);
    boundary  = frame_end || !run_q;
    take      = boundary && (!run_q || (grp_q >= grp_top) || (res_n_i != res_q));
    cfg_en    = boundary;
    cnt_en    = tick_i || boundary;
    thr_en    = take;
    grp_en    = take || frame_end;
    cnt_d     = boundary ? '0 : cnt_q + SAMPLE_W'(1);
    grp_d     = take ? '0 : grp_q + GRP_W'(1);
    thr_d     = take ? SAMPLE_W'(sample_i >> (FULL_RES - res_n_i)) : thr_q;
    pwm_d     = (cnt_en ? cnt_d : cnt_q) < thr_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      res_q  <= FULL_RES;
      per_q  <= PER_W'(1);
      gexp_q <= '0;
      grp_q  <= '0;
      thr_q  <= '0;
      pwm_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      pwm_q <= pwm_d;
      req_q <= take;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (cfg_en) begin
        res_q  <= res_n_i;
        per_q  <= per_n_i;
        gexp_q <= gexp_n_i;
      end
      if (grp_en) begin
        grp_q <= grp_d;
      end
      if (thr_en) begin
        thr_q <= thr_d;
      end
    end
  end

  assign run_o      = run_q;
  assign boundary_o = boundary;
  assign per_o      = per_q;
  assign res_o      = res_q;
  assign thr_o      = thr_q;
  assign cnt_o      = cnt_q;
  assign pwm_o      = pwm_q;
  assign req_o      = req_q;
endmodule

// File: rtl/tone_pwm_gen.sv
`timescale 1ns/1ps
// Octave-adaptive PWM tone generator, top level.
module tone_pwm_gen #(
  parameter int SAMPLE_W = 8,
  parameter int OCT_W    = 4,
  parameter int DIV_W    = 8,
  parameter int FULL_OCT = 4,
  parameter int TOP_OCT  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tone_mode,
  input  logic [OCT_W-1:0]    oct_sel,
  input  logic [DIV_W-1:0]    fine_div,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                pwm_out,
  output logic                sample_req
);
  localparam int RES_W  = $clog2(SAMPLE_W + 1);
  localparam int PER_W  = DIV_W + FULL_OCT;
  localparam int GEXP_W = $clog2(TOP_OCT + 1);
  localparam int GRP_W  = TOP_OCT;

  logic                rst_meta, rst_sync_n;
  logic [RES_W-1:0]    res_n, cur_res;
  logic [PER_W-1:0]    per_n, cur_per;
  logic [GEXP_W-1:0]   gexp_n;
  logic [SAMPLE_W-1:0] cur_thr, cur_cnt;
  logic                run, tick, boundary;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tone_oct_map #(
    .SAMPLE_W(SAMPLE_W), .OCT_W(OCT_W), .DIV_W(DIV_W),
    .FULL_OCT(FULL_OCT), .TOP_OCT(TOP_OCT)
  ) u_map (
    .mode_i (tone_mode),
    .oct_i  (oct_sel),
    .div_i  (fine_div),
    .res_o  (res_n),
    .per_o  (per_n),
    .gexp_o (gexp_n)
  );

  tone_prescaler #(.PER_W(PER_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (run),
    .per_i  (cur_per),
    .tick_o (tick)
  );

  tone_frame_core #(
    .SAMPLE_W(SAMPLE_W), .RES_W(RES_W), .PER_W(PER_W),
    .GEXP_W(GEXP_W), .GRP_W(GRP_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick),
    .sample_i   (sample_in),
    .res_n_i    (res_n),
    .per_n_i    (per_n),
    .gexp_n_i   (gexp_n),
    .run_o      (run),
    .boundary_o (boundary),
    .per_o      (cur_per),
    .res_o      (cur_res),
    .thr_o      (cur_thr),
    .cnt_o      (cur_cnt),
    .pwm_o      (pwm_out),
    .req_o      (sample_req)
  );
endmodule

// File: rtl/tone_pwm_gen_chk.sv
`timescale 1ns/1ps
module tone_pwm_gen_chk #(
  parameter int SAMPLE_W = 8,
  parameter int OCT_W    = 4,
  parameter int RES_W    = 4,
  parameter int TOP_OCT  = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tone_mode,
  input logic [OCT_W-1:0]    oct_sel,
  input logic                pwm_out,
  input logic                sample_req,
  input logic                boundary,
  input logic [RES_W-1:0]    res_q,
  input logic [SAMPLE_W-1:0] thr_q,
  input logic [SAMPLE_W-1:0] cnt_q
);
  assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |=> !sample_req);

  assert_req_after_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> $past(boundary));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(res_q));

  assert_res_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q >= RES_W'(1)) && (res_q <= RES_W'(SAMPLE_W)));

  assert_cnt_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >> res_q) == '0);

  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> !pwm_out);

  assert_frame_starts_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && (thr_q != '0)) |-> pwm_out);

  assert_octave_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !tone_mode && (oct_sel > OCT_W'(TOP_OCT))) |=> (res_q == RES_W'(1)));
endmodule

bind tone_pwm_gen tone_pwm_gen_chk #(
  .SAMPLE_W(SAMPLE_W), .OCT_W(OCT_W), .RES_W(RES_W), .TOP_OCT(TOP_OCT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tone_mode  (tone_mode),
  .oct_sel    (oct_sel),
  .pwm_out    (pwm_out),
  .sample_req (sample_req),
  .boundary   (boundary),
  .res_q      (cur_res),
  .thr_q      (cur_thr),
  .cnt_q      (cur_cnt)
);

// File: tb/tb_tone_pwm_gen.sv
`timescale 1ns/1ps
module tb_tone_pwm_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tone_mode;
  logic [3:0] oct_sel;
  logic [7:0] fine_div;
  logic [7:0] sample_in;
  logic       pwm_out;
  logic       sample_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tone_pwm_gen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone_mode  (tone_mode),
    .oct_sel    (oct_sel),
    .fine_div   (fine_div),
    .sample_in  (sample_in),
    .pwm_out    (pwm_out),
    .sample_req (sample_req)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        mode;
    logic [3:0]  oct;
    logic [7:0]  div;
    logic [7:0]  smp;
    logic [15:0] interval;
    logic [15:0] high;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 1'b0, 4'd0,  8'd0, 8'h80, 16'd2048, 16'd1024}, // R3 octave 0, step 8
    '{4'd3, 1'b0, 4'd1,  8'd0, 8'h20, 16'd1024, 16'd128},  // R3 octave 1, step 4
    '{4'd3, 1'b0, 4'd3,  8'd1, 8'h40, 16'd512,  16'd128},  // R3 octave 3, step 2
    '{4'd4, 1'b0, 4'd2,  8'd0, 8'h00, 16'd512,  16'd0},    // R4 zero duty
    '{4'd2, 1'b0, 4'd4,  8'd0, 8'd200,16'd128,  16'd100},  // R2 7-bit
    '{4'd4, 1'b0, 4'd6,  8'd2, 8'hFF, 16'd96,   16'd93},   // R4 5-bit, step 3
    '{4'd2, 1'b0, 4'd9,  8'd0, 8'hC0, 16'd4,    16'd3},    // R2 2-bit
    '{4'd2, 1'b0, 4'd10, 8'd4, 8'h80, 16'd10,   16'd5},    // R2 1-bit
    '{4'd5, 1'b0, 4'd10, 8'd4, 8'h7F, 16'd10,   16'd0},    // R5 dropped low bits
    '{4'd6, 1'b0, 4'd15, 8'd0, 8'h80, 16'd2,    16'd1},    // R6 clamp adaptive
    '{4'd9, 1'b1, 4'd10, 8'd0, 8'h80, 16'd256,  16'd128},  // R9 one frame per sample
    '{4'd9, 1'b1, 4'd9,  8'd1, 8'h40, 16'd1024, 16'd256},  // R9 two frames per sample
    '{4'd9, 1'b1, 4'd8,  8'd0, 8'hFF, 16'd1024, 16'd1020}, // R9 four frames per sample
    '{4'd6, 1'b1, 4'd12, 8'd0, 8'd10, 16'd256,  16'd10}    // R6 clamp fixed-rate
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input int tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_req();
    do @(negedge clk); while (!sample_req);
  endtask

  task automatic measure(output int len, output int hi);
    len = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      len++;
      if (pwm_out) hi++;
    end while (!sample_req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    int len, hi, n;
    rst_n = 1'b0; tone_mode = 1'b0; oct_sel = 4'd10; fine_div = 8'd0; sample_in = 8'h80;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(1, "pwm_out in reset", int'(pwm_out), 0);
    check(1, "sample_req in reset", int'(sample_req), 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_req && n < 20);
    check(1, "first request within 6 clocks", int'(n <= 6), 1);

    // R7: request lasts one clock; 1-bit octave 10 gives 2-clock frames
    wait_req(); wait_req();
    @(negedge clk);
    check(7, "request low after pulse", int'(sample_req), 0);
    @(negedge clk);
    check(7, "request each 2-clock frame", int'(sample_req), 1);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      tone_mode = VECS[i].mode;
      oct_sel   = VECS[i].oct;
      fine_div  = VECS[i].div;
      sample_in = VECS[i].smp;
      wait_req(); wait_req(); wait_req();
      measure(len, hi);
      check(int'(VECS[i].tag), $sformatf("vector %0d interval", i), len, int'(VECS[i].interval));
      check(int'(VECS[i].tag), $sformatf("vector %0d high cycles", i), hi, int'(VECS[i].high));
    end

    // R8: mid-frame change must not disturb the running frame
    tone_mode = 1'b0; oct_sel = 4'd0; fine_div = 8'd0; sample_in = 8'h80;
    wait_req(); wait_req(); wait_req();
    len = 0; hi = 0;
    do begin
      @(negedge clk);
      len++;
      if (pwm_out) hi++;
      if (len == 100) oct_sel = 4'd10;
    end while (!sample_req);
    check(8, "frame length kept after change", len, 2048);
    check(8, "duty kept after change", hi, 1024);
    measure(len, hi);
    check(8, "new octave after frame end", len, 2);

    // R1: reset asserted during operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, "pwm_out after async reset", int'(pwm_out), 0);
    check(1, "sample_req after async reset", int'(sample_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_req && n < 20);
    check(1, "request after second reset", int'(n <= 6), 1);

    summary();
  end
endmodule